// File: doc/BRIEF.md
# Low-Power Mode and Clock Controller

This block is the power-down and clock-control section of a small processor core. It runs from the crystal clock. It produces a master clock enable for the rest of the core, a run request for the on-chip oscillator, and a gate for the external clock output. An 8-bit control register, written and read over a plain strobe/data pair, sets three things: whether the master clock runs at the crystal rate or at half that rate, which low-power state a sleep instruction enters, and whether a bus request may end that state. The remaining register bits hold output drive-strength choices. They are only stored and read back.

The core raises `slp_strobe` for one cycle when it executes a sleep instruction. From the run state, the block moves to one of five states. The choice depends on `io_stop` and on control bits 6 and 3. SLEEP and SYSTEM STOP leave the master clock running and end on a wake event. IDLE keeps the oscillator running but blocks its clock. STANDBY and QUICK RECOVERY STANDBY stop the oscillator. On a wake, the block restarts the oscillator and holds the clock off until a stabilisation count has elapsed: 2^17 cycles in STANDBY, 64 cycles in QUICK RECOVERY STANDBY.

All pins are plain control and status. There is no data stream, so no valid/ready handshake and no back-pressure.

Top module: `pwrclk_ctrl`

## Requirements
- R1: After reset, `cfg_rd_data` is 0x00 and `pwr_mode` is RUN. `osc_run` and `clkout_gate` are 1 and `clk_resume` is 0. The `pwr_mode` codes are RUN=0, SLEEP=1, SYSSTOP=2, IDLE=3, STBY=4, QSTBY=5, RESTART=6.
- R2: A write (`cfg_wr_en`=1 at a clock edge) stores all 8 bits of `cfg_wr_data`, and `cfg_rd_data` shows them from the next cycle on. Bits 4, 2 and 1 have no other effect.
- R3: Bit 7 sets the clock divide. In RUN, SLEEP and SYSSTOP, bit 7 = 1 gives `mclk_en` = 1 in every cycle. Bit 7 = 0 gives `mclk_en` alternating 1,0,1,… and it is 1 in the first cycle after a non-running state or after reset.
- R4: `slp_strobe` in RUN with `io_stop`=0 enters SLEEP in the next cycle, whatever the bit 6 and bit 3 settings. The master clock keeps running. `wake_evt` returns the block to RUN in the next cycle.
- R5: `slp_strobe` in RUN with `io_stop`=1 and bits {6,3}=00 enters SYSSTOP. The clock behaves as in SLEEP, and `wake_evt` returns the block to RUN.
- R6: With `io_stop`=1 and {6,3}=01, `slp_strobe` enters IDLE. In IDLE, `osc_run` is 1 while `mclk_en` and `clkout_gate` are 0.
- R7: With `io_stop`=1 and {6,3}=10, `slp_strobe` enters STBY, where `osc_run`, `mclk_en` and `clkout_gate` are 0. A wake moves the block to RESTART (`osc_run`=1, clocks still off) for exactly 131072 cycles, then to RUN.
- R8: With `io_stop`=1 and {6,3}=11, `slp_strobe` enters QSTBY. It behaves as STBY except that RESTART lasts exactly 64 cycles.
- R9: When bit 5 is 1, `bus_req` ends IDLE (to RUN), STBY and QSTBY (to RESTART) just as `wake_evt` does. In STBY and QSTBY the clock returns only after the stabilisation count. When bit 5 is 0, `bus_req` leaves the state unchanged.
- R10: `clk_resume` is 1 for exactly one cycle: the first RUN cycle after IDLE or RESTART. In that cycle `mclk_en` is 1.
- R11: `slp_strobe` outside RUN is ignored. `wake_evt` and `bus_req` during RESTART are ignored.
- R12: Every entry into STBY or QSTBY reloads the stabilisation count, so back-to-back standby cycles each wait the full delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_wr_data | input | 8 | Control register write value |
| cfg_rd_data | output | 8 | Control register contents |
| slp_strobe | input | 1 | Sleep instruction executed (one cycle) |
| io_stop | input | 1 | I/O-stop flag from the I/O control register |
| bus_req | input | 1 | External bus request |
| wake_evt | input | 1 | Interrupt or other wake event |
| mclk_en | output | 1 | Master clock enable |
| osc_run | output | 1 | Oscillator run request |
| clkout_gate | output | 1 | Clock output pin enable |
| pwr_mode | output | 3 | Current state code (see R1) |
| clk_resume | output | 1 | One-cycle pulse when the master clock restarts |

## Verification
A wrong state register shows up on `pwr_mode` one cycle after the faulty edge. It also shows up on the clock outputs in that same cycle, because `osc_run`, `clkout_gate` and `mclk_en` all follow the state directly. A wrong divide phase shows on `mclk_en` within two cycles. A wrong stabilisation count has no visible effect until the exit. It appears as a RESTART state that is one or more cycles too short or too long, and the bench measures that length against 64 and 131072. A wrong control register bit appears on `cfg_rd_data` in the cycle after the write.

// File: rtl/pwrclk_pkg.sv
package pwrclk_pkg;

  typedef enum logic [2:0] {
    PM_RUN     = 3'd0,
    PM_SLEEP   = 3'd1,
    PM_SYSSTOP = 3'd2,
    PM_IDLE    = 3'd3,
    PM_STBY    = 3'd4,
    PM_QSTBY   = 3'd5,
    PM_RESTART = 3'd6
  } pm_mode_e;

  // control register bit positions that the state logic decodes
  localparam int CFG_DIV1    = 7;
  localparam int CFG_SEL_HI  = 6;
  localparam int CFG_BUSWAKE = 5;
  localparam int CFG_SEL_LO  = 3;

  function automatic logic is_running(pm_mode_e m);
    return (m == PM_RUN) || (m == PM_SLEEP) || (m == PM_SYSSTOP);
  endfunction

endpackage

// File: rtl/pwrclk_cfgreg.sv
module pwrclk_cfgreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= wr_data;
  end
endmodule

// File: rtl/pwrclk_clkgate.sv
module pwrclk_clkgate (
  input  logic clk,
  input  logic rst_n,
  input  logic running,
  input  logic div1,
  output logic mclk_en
);
  logic phase_q;

  // phase restarts at 0 whenever the clock has been blocked
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= running ? ~phase_q : 1'b0;
  end

  assign mclk_en = running & (div1 | ~phase_q);
endmodule

// File: rtl/pwrclk_stab.sv
module pwrclk_stab #(
  parameter int LONG_LOG2 = 17,
  parameter int SHORT_LEN = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic load_long,
  input  logic run,
  output logic done
);
  localparam int CNT_W = (LONG_LOG2 > $clog2(SHORT_LEN)) ? LONG_LOG2 : $clog2(SHORT_LEN);
  localparam logic [CNT_W-1:0] LONG_V  = CNT_W'((64'd1 << LONG_LOG2) - 64'd1);
  localparam logic [CNT_W-1:0] SHORT_V = CNT_W'(SHORT_LEN - 1);

  logic [CNT_W-1:0] cnt_q;

  assign done = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load)        cnt_q <= load_long ? LONG_V : SHORT_V;
    else if (run && !done) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/pwrclk_ctrl.sv
module pwrclk_ctrl
  import pwrclk_pkg::*;
#(
  parameter int CFG_W      = 8,
  parameter int STAB_LOG2  = 17,
  parameter int STAB_SHORT = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [CFG_W-1:0] cfg_wr_data,
  output logic [CFG_W-1:0] cfg_rd_data,
  input  logic             slp_strobe,
  input  logic             io_stop,
  input  logic             bus_req,
  input  logic             wake_evt,
  output logic             mclk_en,
  output logic             osc_run,
  output logic             clkout_gate,
  output logic [2:0]       pwr_mode,
  output logic             clk_resume
);
  pm_mode_e   mode_q, mode_d;
  logic [CFG_W-1:0] cfg_q;
  logic       stab_done, stab_load, running, exit_req, resume_d;

  pwrclk_cfgreg #(.W(CFG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data), .q(cfg_q)
  );

  assign running  = is_running(mode_q);
  assign exit_req = wake_evt | (bus_req & cfg_q[CFG_BUSWAKE]);

  pwrclk_clkgate u_gate (
    .clk(clk), .rst_n(rst_n), .running(running), .div1(cfg_q[CFG_DIV1]), .mclk_en(mclk_en)
  );

  assign stab_load = (mode_q == PM_RUN) & slp_strobe & io_stop & cfg_q[CFG_SEL_HI];

  pwrclk_stab #(.LONG_LOG2(STAB_LOG2), .SHORT_LEN(STAB_SHORT)) u_stab (
    .clk(clk), .rst_n(rst_n), .load(stab_load), .load_long(~cfg_q[CFG_SEL_LO]),
    .run(mode_q == PM_RESTART), .done(stab_done)
  );

  always_comb begin
    mode_d   = mode_q;
    resume_d = 1'b0;
    unique case (mode_q)
      PM_RUN: if (slp_strobe) begin
        if (!io_stop) mode_d = PM_SLEEP;
        else begin
          unique case ({cfg_q[CFG_SEL_HI], cfg_q[CFG_SEL_LO]})
            2'b00:   mode_d = PM_SYSSTOP;
            2'b01:   mode_d = PM_IDLE;
            2'b10:   mode_d = PM_STBY;
            default: mode_d = PM_QSTBY;
          endcase
        end
      end
      PM_SLEEP, PM_SYSSTOP: if (wake_evt) mode_d = PM_RUN;
      PM_IDLE: if (exit_req) begin
        mode_d   = PM_RUN;
        resume_d = 1'b1;
      end
      PM_STBY, PM_QSTBY: if (exit_req) mode_d = PM_RESTART;
      PM_RESTART: if (stab_done) begin
        mode_d   = PM_RUN;
        resume_d = 1'b1;
      end
      default: mode_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= PM_RUN;
      clk_resume <= 1'b0;
    end else begin
      mode_q     <= mode_d;
      clk_resume <= resume_d;
    end
  end

  assign cfg_rd_data = cfg_q;
  assign osc_run     = (mode_q != PM_STBY) && (mode_q != PM_QSTBY);
  assign clkout_gate = running;
  assign pwr_mode    = mode_q;
endmodule

// File: rtl/pwrclk_ctrl_chk.sv
module pwrclk_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wr_en,
  input logic [7:0] cfg_wr_data,
  input logic [7:0] cfg_rd_data,
  input logic       slp_strobe,
  input logic       io_stop,
  input logic       bus_req,
  input logic       wake_evt,
  input logic       mclk_en,
  input logic       osc_run,
  input logic       clkout_gate,
  input logic [2:0] pwr_mode,
  input logic       clk_resume
);
  // R2
  cfg_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |=> cfg_rd_data == $past(cfg_wr_data));

  // R3
  div1_full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_data[7] && pwr_mode == 3'd0 && $past(pwr_mode) == 3'd0) |-> mclk_en);

  // R4
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 3'd0 && slp_strobe && !io_stop) |=> pwr_mode == 3'd1);

  // R7
  osc_off_blocks_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_run |-> (!mclk_en && !clkout_gate));

  // R9
  bus_ignored_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 3'd3 && !wake_evt && !(bus_req && cfg_rd_data[5])) |=> pwr_mode == 3'd3);

  // R10
  resume_with_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_resume |-> (mclk_en && pwr_mode == 3'd0));

  // R10
  resume_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_resume |=> !clk_resume);

  // R11
  restart_exit_only_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_mode == 3'd6 |=> (pwr_mode == 3'd6 || pwr_mode == 3'd0));

  // R11
  sleep_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 3'd1 && !wake_evt) |=> pwr_mode == 3'd1);
endmodule

bind pwrclk_ctrl pwrclk_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
  .cfg_rd_data(cfg_rd_data), .slp_strobe(slp_strobe), .io_stop(io_stop),
  .bus_req(bus_req), .wake_evt(wake_evt), .mclk_en(mclk_en), .osc_run(osc_run),
  .clkout_gate(clkout_gate), .pwr_mode(pwr_mode), .clk_resume(clk_resume)
);

// File: tb/pwrclk_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwrclk_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr_en = 1'b0;
  logic [7:0] cfg_wr_data = 8'h00;
  logic [7:0] cfg_rd_data;
  logic       slp_strobe = 1'b0, io_stop = 1'b0, bus_req = 1'b0, wake_evt = 1'b0;
  logic       mclk_en, osc_run, clkout_gate, clk_resume;
  logic [2:0] pwr_mode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwrclk_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .slp_strobe(slp_strobe), .io_stop(io_stop),
    .bus_req(bus_req), .wake_evt(wake_evt), .mclk_en(mclk_en), .osc_run(osc_run),
    .clkout_gate(clkout_gate), .pwr_mode(pwr_mode), .clk_resume(clk_resume)
  );

  // ---------------- reference model ----------------
  int m_mode = 0;
  int m_cfg = 0;
  int m_phase = 0;
  int m_left = 0;
  int m_resume = 0;

  function automatic string tag_of(int md);
    case (md)
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      6: return "R7";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_cfg = 0; m_phase = 0; m_left = 0; m_resume = 0;
    end else begin
      automatic bit run = (m_mode <= 2);
      automatic bit ex  = wake_evt || (bus_req && m_cfg[5]);
      automatic int nm  = m_mode;
      m_resume = 0;
      case (m_mode)
        0: if (slp_strobe) begin
             if (!io_stop) nm = 1;
             else if (!m_cfg[6]) nm = m_cfg[3] ? 3 : 2;
             else begin
               nm = m_cfg[3] ? 5 : 4;
               m_left = m_cfg[3] ? 64 : 131072;
             end
           end
        1, 2: if (wake_evt) nm = 0;
        3: if (ex) begin nm = 0; m_resume = 1; end
        4, 5: if (ex) nm = 6;
        6: begin
             m_left--;
             if (m_left == 0) begin nm = 0; m_resume = 1; end
           end
        default: nm = 0;
      endcase
      m_phase = run ? 1 - m_phase : 0;
      m_mode = nm;
      if (cfg_wr_en) m_cfg = cfg_wr_data;
    end
    #2;
    if (rst_n && !done) begin
      automatic bit run2 = (m_mode <= 2);
      chk(tag_of(m_mode), "pwr_mode", pwr_mode, m_mode);
      chk("R2", "cfg_rd_data", cfg_rd_data, m_cfg);
      chk("R3", "mclk_en", mclk_en, run2 && (m_cfg[7] || m_phase == 0));
      chk(tag_of(m_mode), "osc_run", osc_run, !(m_mode == 4 || m_mode == 5));
      chk(tag_of(m_mode), "clkout_gate", clkout_gate, run2);
      chk("R10", "clk_resume", clk_resume, m_resume);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cfg(logic [7:0] v);
    @(negedge clk); cfg_wr_en = 1'b1; cfg_wr_data = v;
    @(negedge clk); cfg_wr_en = 1'b0;
  endtask

  task automatic pulse_slp(logic stop);
    @(negedge clk); io_stop = stop; slp_strobe = 1'b1;
    @(negedge clk); slp_strobe = 1'b0;
  endtask

  task automatic pulse_wake();
    @(negedge clk); wake_evt = 1'b1;
    @(negedge clk); wake_evt = 1'b0;
  endtask

  // counts RESTART cycles, sampled at negedge, until RUN is reached
  task automatic measure_restart(string req, int exp);
    int n = 0;
    while (pwr_mode == 3'd6 && n < 140000) begin
      n++;
      @(negedge clk);
    end
    chk(req, "restart length", n, exp);
    chk("R10", "resume pulse at exit", clk_resume, 1);
    chk("R10", "mclk_en at exit", mclk_en, 1);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "reset cfg", cfg_rd_data, 0);
    chk("R1", "reset mode", pwr_mode, 0);
    chk("R1", "reset osc_run", osc_run, 1);
    chk("R1", "reset clkout_gate", clkout_gate, 1);
    chk("R1", "reset clk_resume", clk_resume, 0);
    cyc(6);
    // R3 undivided clock, R2 drive bits readback
    wr_cfg(8'h80); cyc(6);
    wr_cfg(8'h96); cyc(1);
    chk("R2", "drive bits readback", cfg_rd_data, 8'h96);
    // R4 sleep, R11 extra sleep strobe ignored
    wr_cfg(8'h48);
    pulse_slp(1'b0);
    chk("R4", "sleep entry", pwr_mode, 1);
    pulse_slp(1'b1); cyc(2);
    chk("R11", "strobe ignored in sleep", pwr_mode, 1);
    pulse_wake(); cyc(2);
    chk("R4", "sleep exit", pwr_mode, 0);
    // R5 system stop
    wr_cfg(8'h00);
    pulse_slp(1'b1);
    chk("R5", "sysstop entry", pwr_mode, 2);
    cyc(3); pulse_wake(); cyc(3);
    // R6 idle, R9 bus request ignored with bit5=0
    wr_cfg(8'h08);
    pulse_slp(1'b1);
    chk("R6", "idle entry", pwr_mode, 3);
    @(negedge clk); bus_req = 1'b1; cyc(4); bus_req = 1'b0;
    chk("R9", "bus_req ignored in idle", pwr_mode, 3);
    pulse_wake(); cyc(3);
    // R9 bus request exits idle with bit5=1
    wr_cfg(8'h28);
    pulse_slp(1'b1);
    @(negedge clk); bus_req = 1'b1; @(negedge clk); bus_req = 1'b0;
    chk("R9", "bus_req exits idle", pwr_mode, 0);
    cyc(3);
    // R8 quick standby; R11 wake ignored during restart
    wr_cfg(8'h48);
    pulse_slp(1'b1); cyc(5);
    chk("R8", "qstby entry", pwr_mode, 5);
    @(negedge clk); wake_evt = 1'b1; @(negedge clk); wake_evt = 1'b0;
    cyc(3); wake_evt = 1'b1; @(negedge clk); wake_evt = 1'b0;
    chk("R11", "wake ignored in restart", pwr_mode, 6);
    measure_restart("R8", 60);
    cyc(4);
    // R12 second quick standby, bus wake, full delay again
    wr_cfg(8'h68);
    pulse_slp(1'b1); cyc(2);
    @(negedge clk); bus_req = 1'b1; @(negedge clk); bus_req = 1'b0;
    measure_restart("R12", 64);
    cyc(4);
    // R7 long standby, bus request ignored with bit5=0
    wr_cfg(8'h40);
    pulse_slp(1'b1);
    chk("R7", "stby entry", pwr_mode, 4);
    @(negedge clk); bus_req = 1'b1; cyc(3); bus_req = 1'b0;
    chk("R9", "bus_req ignored in stby", pwr_mode, 4);
    @(negedge clk); wake_evt = 1'b1; @(negedge clk); wake_evt = 1'b0;
    measure_restart("R7", 131072);
    cyc(5);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule